// File: doc/BRIEF.md
# Framed Serial Command Dispatcher for a Sine/Cosine Unit

This block takes bytes from a UART receiver, one byte per `rx_valid` strobe, and decodes them as short framed commands. Every command opens with a sync byte, and an opcode byte follows it. Two opcodes request a sine/cosine calculation. Each one picks a different precision variant of the compute unit, then gathers a 32-bit phase argument from the next four bytes and starts the unit with a one-cycle pulse. When the unit reports completion, the block captures both 32-bit results. It then sends them to the UART transmitter as eight bytes, sine first, least significant byte first. The transmitter paces this stream with a ready/valid handshake.

Two other opcodes switch a clock-enable modulation mode on or off, and they send no reply. While a calculation or a reply is in progress the block takes no new command, so bytes that arrive in that time are dropped. Three mutually exclusive flags show the activity: ready for a command, calculating, and transmitting. A fourth flag shows the modulation mode, which does not depend on the other three.

Top module: `sc_cmd_dispatch`

## Requirements
- R1: A byte received in the sync position that is not 0x41 is dropped, and the block stays waiting for a sync byte. No calculation follows from it.
- R2: After 0x41, opcode 0x42 starts the lower-precision variant (`calc_prec` = 0) and opcode 0x43 starts the higher-precision variant (`calc_prec` = 1).
- R3: After a calculation opcode, the next four received bytes form `calc_phase`, with the first byte in bits 7:0 and the fourth in bits 31:24. `calc_start` is asserted in the cycle after the fourth byte is accepted.
- R4: After `calc_done`, exactly eight bytes leave on `tx_data`: sine bits 7:0, 15:8, 23:16, 31:24, then cosine bits in the same order.
- R5: After 0x41, opcode 0x44 sets `mod_active` and opcode 0x45 clears it. Neither opcode produces any transmitted byte.
- R6: After 0x41, any other opcode returns the block to waiting for sync, with no calculation and no change to `mod_active`.
- R7: Bytes received while `busy_calc` or `sending` is high are ignored. They start nothing and change nothing.
- R8: Exactly one of `ready`, `busy_calc` and `sending` is high at any time. `mod_active` keeps its value through calculations and replies.
- R9: The reply advances only on a cycle where `tx_valid` and `tx_ready` are both high. While the transmitter stalls, `tx_data` holds its value.
- R10: Reset returns the block to waiting for sync, clears `mod_active` and drops any partly received command.
- R11: `calc_start` is a single-cycle pulse for each calculation command, raised together with `busy_calc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_valid | input | 1 | A received byte is present on rx_data this cycle |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte this cycle |
| tx_valid | output | 1 | A reply byte is offered on tx_data |
| tx_data | output | 8 | Reply byte |
| calc_start | output | 1 | One-cycle start pulse to the compute unit |
| calc_prec | output | 1 | Variant select: 0 lower precision, 1 higher precision |
| calc_phase | output | 32 | Phase argument |
| calc_done | input | 1 | Compute unit has results on calc_sin/calc_cos |
| calc_sin | input | 32 | Sine result |
| calc_cos | input | 32 | Cosine result |
| ready | output | 1 | Waiting for or receiving a command |
| busy_calc | output | 1 | Calculation in progress |
| mod_active | output | 1 | Clock-enable modulation mode is on |
| sending | output | 1 | Reply transmission in progress |

## Verification
Calculations use both precision opcodes with phases whose four bytes all differ, so a swapped byte order or a wrong variant select gives a visibly wrong phase or result stream. Replies are taken once with the transmitter always ready and once with a pseudo-random stall pattern, which shows apart a serializer that waits for the handshake from one that advances on its own. Junk bytes before sync, unknown opcodes, mode commands sent during a calculation, and a reset in the middle of a command each check that state the block must not touch really stays unchanged.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    ST_SYNC = 3'd0,
    ST_OP   = 3'd1,
    ST_ARG  = 3'd2,
    ST_CALC = 3'd3,
    ST_SEND = 3'd4
  } disp_state_t;
endpackage

// File: rtl/sc_cmd_parser.sv
module sc_cmd_parser
  import sc_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 32,
  parameter logic [BYTE_W-1:0] SYNC_B = 8'h41,
  parameter logic [BYTE_W-1:0] OP_LO  = 8'h42,
  parameter logic [BYTE_W-1:0] OP_HI  = 8'h43,
  parameter logic [BYTE_W-1:0] OP_MON = 8'h44,
  parameter logic [BYTE_W-1:0] OP_MOF = 8'h45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              calc_done,
  input  logic              ser_last,
  output disp_state_t       state,
  output logic              calc_start,
  output logic              calc_prec,
  output logic [WORD_W-1:0] calc_phase,
  output logic              mod_en,
  output logic              res_load
);
  localparam int NB = WORD_W / BYTE_W;
  localparam int CW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(NB - 1);

  disp_state_t       st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0] ph_q, ph_d;
  logic              prec_q, prec_d;
  logic              mod_q, mod_d;
  logic              start_q, start_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    ph_d    = ph_q;
    prec_d  = prec_q;
    mod_d   = mod_q;
    start_d = 1'b0;
    case (st_q)
      ST_SYNC: if (rx_valid && rx_data == SYNC_B) st_d = ST_OP;
      ST_OP: if (rx_valid) begin
        st_d = ST_SYNC;
        if (rx_data == OP_LO || rx_data == OP_HI) begin
          prec_d = (rx_data == OP_HI);
          cnt_d  = '0;
          st_d   = ST_ARG;
        end else if (rx_data == OP_MON) begin
          mod_d = 1'b1;
        end else if (rx_data == OP_MOF) begin
          mod_d = 1'b0;
        end
      end
      ST_ARG: if (rx_valid) begin
        ph_d = {rx_data, ph_q[WORD_W-1:BYTE_W]};
        if (cnt_q == LAST_IDX) begin
          st_d    = ST_CALC;
          start_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CALC: if (calc_done) st_d = ST_SEND;
      ST_SEND: if (ser_last) st_d = ST_SYNC;
      default: st_d = ST_SYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SYNC;
      cnt_q   <= '0;
      ph_q    <= '0;
      prec_q  <= 1'b0;
      mod_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ph_q    <= ph_d;
      prec_q  <= prec_d;
      mod_q   <= mod_d;
      start_q <= start_d;
    end
  end

  assign state      = st_q;
  assign calc_start = start_q;
  assign calc_prec  = prec_q;
  assign calc_phase = ph_q;
  assign mod_en     = mod_q;
  assign res_load   = (st_q == ST_CALC) && calc_done;

  // R1: a non-sync byte in the sync slot keeps the parser in the sync slot
  p_sync_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SYNC && rx_valid && rx_data != SYNC_B) |=> (st_q == ST_SYNC));

  // R5: mode-on opcode sets the mode flag on the next cycle
  p_mod_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OP && rx_valid && rx_data == OP_MON) |=> mod_q);

  // R11: start is a one-cycle pulse
  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R3: start only ever accompanies the calculating state
  p_start_calc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (st_q == ST_CALC));
endmodule

// File: rtl/sc_resp_ser.sv
module sc_resp_ser #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] sin_in,
  input  logic [WORD_W-1:0] cos_in,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              last
);
  localparam int NBYTES = 2 * WORD_W / BYTE_W;
  localparam int CW     = $clog2(NBYTES);
  localparam logic [CW-1:0] LAST_IDX = CW'(NBYTES - 1);

  logic [2*WORD_W-1:0] sh_q, sh_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                vld_q, vld_d;
  logic                fire;

  assign fire = vld_q && tx_ready;
  assign last = fire && (cnt_q == LAST_IDX);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (load) begin
      sh_d  = {cos_in, sin_in};
      cnt_d = '0;
      vld_d = 1'b1;
    end else if (fire) begin
      sh_d  = sh_q >> BYTE_W;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign tx_valid = vld_q;
  assign tx_data  = sh_q[BYTE_W-1:0];

  // R9: a stalled byte stays offered and unchanged
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !tx_ready) |=> (vld_q && $stable(tx_data)));
endmodule

// File: rtl/sc_cmd_dispatch.sv
module sc_cmd_dispatch
  import sc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              calc_start,
  output logic              calc_prec,
  output logic [WORD_W-1:0] calc_phase,
  input  logic              calc_done,
  input  logic [WORD_W-1:0] calc_sin,
  input  logic [WORD_W-1:0] calc_cos,
  output logic              ready,
  output logic              busy_calc,
  output logic              mod_active,
  output logic              sending
);
  disp_state_t st;
  logic        res_load;
  logic        ser_last;

  sc_cmd_parser #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_parse (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .calc_done  (calc_done),
    .ser_last   (ser_last),
    .state      (st),
    .calc_start (calc_start),
    .calc_prec  (calc_prec),
    .calc_phase (calc_phase),
    .mod_en     (mod_active),
    .res_load   (res_load)
  );

  sc_resp_ser #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (res_load),
    .sin_in   (calc_sin),
    .cos_in   (calc_cos),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .last     (ser_last)
  );

  always_comb begin
    ready     = (st == ST_SYNC) || (st == ST_OP) || (st == ST_ARG);
    busy_calc = (st == ST_CALC);
    sending   = (st == ST_SEND);
  end

  // R8: activity flags are one-hot
  p_flags_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ready, busy_calc, sending}) == 1);

  // R7: bytes arriving while busy leave the mode flag untouched
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_calc || sending) && rx_valid) |=> $stable(mod_active));

  // R4: the serializer only offers bytes while the sending flag is up
  p_tx_in_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> sending);
endmodule

// File: tb/tb_sc_cmd_dispatch.sv
`timescale 1ns/1ps
module tb_sc_cmd_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_ready = 1'b1;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        calc_start, calc_prec;
  logic [31:0] calc_phase;
  logic        calc_done = 1'b0;
  logic [31:0] calc_sin = '0, calc_cos = '0;
  logic        ready, busy_calc, mod_active, sending;

  always #2 clk = ~clk;

  sc_cmd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .calc_start(calc_start), .calc_prec(calc_prec), .calc_phase(calc_phase),
    .calc_done(calc_done), .calc_sin(calc_sin), .calc_cos(calc_cos),
    .ready(ready), .busy_calc(busy_calc), .mod_active(mod_active), .sending(sending)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_starts = 0;
  logic [7:0]  exp_q[$];
  logic [31:0] exp_phase = '0;
  logic        exp_prec = 1'b0;
  logic        stall_en = 1'b0;
  logic [7:0]  lfsr = 8'h5B;
  bit          finished = 0;

  function automatic logic [31:0] f_sin(input logic [31:0] p, input logic pr);
    return pr ? ({p[15:0], p[31:16]} ^ 32'h1357_9BDF) : (p ^ 32'hA5A5_C3C3);
  endfunction
  function automatic logic [31:0] f_cos(input logic [31:0] p, input logic pr);
    return pr ? ~p : (p + 32'h0102_0304);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400 && !ready; i++) @(negedge clk);
  endtask

  task automatic do_calc(input logic [7:0] op, input logic [31:0] ph);
    exp_phase = ph;
    exp_prec  = (op == 8'h43);
    send_byte(8'h41);
    send_byte(op);
    for (int k = 0; k < 4; k++) send_byte(ph[8*k +: 8]);
  endtask

  // transmitter readiness pattern
  initial forever begin
    @(negedge clk);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready = stall_en ? lfsr[0] : 1'b1;
  end

  // compute-unit stub and scoreboard producer
  initial forever begin
    @(negedge clk);
    if (calc_start) begin
      logic [31:0] s, c;
      int lat;
      n_starts++;
      check(calc_prec == exp_prec, "R2 variant select", {31'd0, calc_prec}, {31'd0, exp_prec});
      check(calc_phase == exp_phase, "R3 phase assembly", calc_phase, exp_phase);
      check(busy_calc, "R11 start with calculating flag", {31'd0, busy_calc}, 32'd1);
      s = f_sin(calc_phase, calc_prec);
      c = f_cos(calc_phase, calc_prec);
      for (int k = 0; k < 4; k++) exp_q.push_back(s[8*k +: 8]);
      for (int k = 0; k < 4; k++) exp_q.push_back(c[8*k +: 8]);
      lat = 2 + int'(calc_phase[1:0]);
      @(negedge clk);
      check(!calc_start, "R11 single-cycle start", {31'd0, calc_start}, 32'd0);
      for (int k = 1; k < lat; k++) @(negedge clk);
      calc_sin  = s;
      calc_cos  = c;
      calc_done = 1'b1;
      @(negedge clk);
      calc_done = 1'b0;
    end
  end

  // scoreboard consumer and flag monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if ($countones({ready, busy_calc, sending}) != 1) begin
        n_cmp++; n_bad++;
        $display("FAIL R8 flags actual=%b expected one-hot", {ready, busy_calc, sending});
      end
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, "R4/R5 unexpected reply byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(tx_data == e, "R4 R9 reply byte", {24'd0, tx_data}, {24'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(ready && !busy_calc && !sending && !mod_active && !tx_valid && !calc_start,
          "R10 reset state", {27'd0, ready, busy_calc, sending, mod_active, tx_valid}, 32'h10);

    // R1: junk without sync must not start anything
    s0 = n_starts;
    send_byte(8'h42); send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
    repeat (3) @(negedge clk);
    check(n_starts == s0 && ready, "R1 no sync no start", n_starts, s0);

    // R2 R3 R4 lower precision, always-ready transmitter
    do_calc(8'h42, 32'h8C4D_2E17);
    wait_ready();
    check(exp_q.size() == 0, "R4 all bytes sent (low)", exp_q.size(), 0);

    // R5 mode on, no reply
    send_byte(8'h41); send_byte(8'h44);
    repeat (4) @(negedge clk);
    check(mod_active == 1'b1, "R5 mode on", {31'd0, mod_active}, 32'd1);
    check(!tx_valid && ready, "R5 no reply to mode command", {31'd0, tx_valid}, 32'd0);

    // R9 R8 high precision with stalls; mode retained
    stall_en = 1'b1;
    do_calc(8'h43, 32'h3B96_F1A0);
    wait_ready();
    stall_en = 1'b0;
    check(exp_q.size() == 0, "R4 all bytes sent (high, stalled)", exp_q.size(), 0);
    check(mod_active, "R8 mode kept across calculation", {31'd0, mod_active}, 32'd1);

    // R6 unknown opcode: no start, mode untouched
    s0 = n_starts;
    send_byte(8'h41); send_byte(8'h47);
    send_byte(8'h10); send_byte(8'h20); send_byte(8'h30); send_byte(8'h40);
    repeat (3) @(negedge clk);
    check(n_starts == s0, "R6 unknown opcode starts nothing", n_starts, s0);
    check(mod_active && ready, "R6 mode untouched", {31'd0, mod_active}, 32'd1);

    // R5 mode off
    send_byte(8'h41); send_byte(8'h45);
    @(negedge clk);
    check(!mod_active, "R5 mode off", {31'd0, mod_active}, 32'd0);

    // R7 mode command while calculating is ignored
    stall_en = 1'b1;
    do_calc(8'h42, 32'h0000_0003);
    s0 = n_starts;
    send_byte(8'h41); send_byte(8'h44);
    wait_ready();
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    check(!mod_active, "R7 mode command ignored while busy", {31'd0, mod_active}, 32'd0);
    check(n_starts == s0 && exp_q.size() == 0, "R7 no extra start", n_starts, s0);

    // R10 reset mid-command
    send_byte(8'h41); send_byte(8'h44);
    send_byte(8'h41); send_byte(8'h42); send_byte(8'h11);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mod_active && ready, "R10 reset clears mode", {31'd0, mod_active}, 32'd0);
    s0 = n_starts;
    send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    repeat (3) @(negedge clk);
    check(n_starts == s0 && !busy_calc, "R10 partial command dropped", n_starts, s0);

    // R2 low precision again, different phase
    do_calc(8'h42, 32'hFEDC_BA98);
    wait_ready();
    check(exp_q.size() == 0, "R4 all bytes sent (final)", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule